// File: doc/BRIEF.md
# Serial DAC Frame Shifter

This block sends 16-bit words to a serial digital-to-analog converter. It sits next to the converter's three-wire input and turns a parallel write into one serial frame. The host presents a word on `wr_data` together with a single-cycle `wr_en` pulse. The block then pulls the active-low frame select `sync_n` low and runs a serial clock `sclk` at half the system clock rate. It shifts the word out on `sdata`, most significant bit first, and raises `sync_n` again once the converter has taken the last bit. The word is passed through unchanged. Any control bits inside it belong to the host.

The first falling edge of `sclk` coincides with the fall of `sync_n` and only opens the frame. Data is launched on every rising edge of `sclk` and is sampled by the converter on the falling edge that follows. The frame closes on the rising edge after the sixteenth of those sampling edges. `busy` stays high from the accepted write until a short guard interval after the frame has closed. Strobes that arrive while `busy` is high have no effect.

Top module: `dac_frame_shifter`

## Requirements
- R1: When `busy` is low, a `wr_en` pulse captures `wr_data`, and the 16 bits are sent on `sdata` most significant bit first, one bit per `sclk` period.
- R2: `sync_n` goes low on the same system clock edge on which `sclk` falls from its idle high level.
- R3: While `sync_n` is low, `sdata` changes only on system clock edges where `sclk` rises, so it is stable across every falling edge of `sclk`.
- R4: After the frame-opening edge, `sclk` falls exactly 16 times while `sync_n` is low. `sync_n` rises together with the next rising edge of `sclk`, and at that point `sdata` returns to 0.
- R5: `sclk` toggles on every system clock edge during a frame, so it runs at half the system clock rate. The bit counter is cleared by each accepted write, so `sync_n` is low for exactly 2*16+1 = 33 system clock cycles in every frame.
- R6: Whenever `busy` is low, `sync_n` is 1, `sclk` is 1 and `sdata` is 0.
- R7: `busy` rises on the edge that accepts a write. It falls GAP_CYCLES (default 2) cycles after `sync_n` rises. A `wr_en` pulse seen while `busy` is high starts no frame.
- R8: Between two frames, `sync_n` stays high for at least GAP_CYCLES+1 system clock cycles, even when `wr_en` is held high all the time.
- R9: Driving `rst_n` low sets all outputs to their idle levels at once, without waiting for a clock edge. The release of reset is synchronised through two flops before the block leaves reset.
- R10: A write strobe only captures the word and starts a frame. A strobe during a frame does not change the bits sent on `sdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 16 | Word to be sent |
| busy | output | 1 | Frame or guard interval in progress |
| sync_n | output | 1 | Active-low frame select to the converter |
| sclk | output | 1 | Serial clock, half the system clock rate, idles high |
| sdata | output | 1 | Serial data, idles low |

## Verification
The assertions assume that `wr_en` and `wr_data` are synchronous to `clk`. They also assume that their checker counters start from reset, because the guard-interval check treats the time before the first frame as an idle interval that is already long enough. The bench drives every input on the falling edge of `clk` and asserts `rst_n` only between edges. A strobe that comes while the block is busy is simply lost: the host must watch `busy` before it writes. The bench therefore issues such strobes only to check that they are ignored, and it never expects them to be queued.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } frame_st_e;

endpackage

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
  import dac_frame_pkg::*;
#(
  parameter int NBITS      = 16,
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  output logic busy,
  output logic sync_n,
  output logic sclk,
  output logic load,
  output logic launch,
  output logic park
);

  localparam int CW = $clog2(NBITS + 1);
  localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(NBITS);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

  frame_st_e     st_q, st_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [GW-1:0] gap_q, gap_nxt;
  logic          sclk_q, sclk_nxt;
  logic          sync_q, sync_nxt;

  always_comb begin
    st_nxt   = st_q;
    cnt_nxt  = cnt_q;
    gap_nxt  = gap_q;
    sclk_nxt = sclk_q;
    sync_nxt = sync_q;
    load     = 1'b0;
    launch   = 1'b0;
    park     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (wr_en) begin
          load     = 1'b1;
          st_nxt   = ST_SHIFT;
          cnt_nxt  = '0;
          sclk_nxt = 1'b0;
          sync_nxt = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (!sclk_q) begin
          sclk_nxt = 1'b1;
          if (cnt_q == CNT_LAST) begin
            park     = 1'b1;
            sync_nxt = 1'b1;
            gap_nxt  = '0;
            st_nxt   = ST_GAP;
          end else begin
            launch = 1'b1;
          end
        end else begin
          sclk_nxt = 1'b0;
          cnt_nxt  = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_LAST) st_nxt = ST_IDLE;
        else                   gap_nxt = gap_q + 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      gap_q  <= '0;
      sclk_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      st_q   <= st_nxt;
      cnt_q  <= cnt_nxt;
      gap_q  <= gap_nxt;
      sclk_q <= sclk_nxt;
      sync_q <= sync_nxt;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign sync_n = sync_q;
  assign sclk   = sclk_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R4
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (st_q == ST_SHIFT) && !sync_q); // R1

endmodule

// File: rtl/dac_frame_piso.sv
module dac_frame_piso #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             launch,
  input  logic             park,
  input  logic [NBITS-1:0] din,
  output logic             sdata
);

  logic [NBITS-1:0] shreg_q, shreg_nxt, shift_in;
  logic             shreg_en;
  logic             sdata_q, sdata_nxt, sdata_en;

  for (genvar i = 0; i < NBITS; i++) begin : g_stage
    if (i == 0) begin : g_tail
      assign shift_in[i] = 1'b0;
    end else begin : g_link
      assign shift_in[i] = shreg_q[i-1];
    end
  end

  always_comb begin
    shreg_en  = load | launch;
    shreg_nxt = load ? din : shift_in;
    sdata_en  = launch | park;
    sdata_nxt = launch ? shreg_q[NBITS-1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      sdata_q <= 1'b0;
    end else begin
      if (shreg_en) shreg_q <= shreg_nxt;
      if (sdata_en) sdata_q <= sdata_nxt;
    end
  end

  assign sdata = sdata_q;

  AST_LOAD_LAUNCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && (launch || park))); // R1

endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int NBITS      = 16,
  parameter int GAP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NBITS-1:0] wr_data,
  output logic             busy,
  output logic             sync_n,
  output logic             sclk,
  output logic             sdata
);

  localparam int FW = $clog2(NBITS + 2) + 1;
  localparam int HW = $clog2(GAP_CYCLES + 2) + 1;
  localparam logic [FW-1:0] FALLS_PER_FRAME = FW'(NBITS + 1);
  localparam logic [HW-1:0] HI_SAT = HW'(GAP_CYCLES + 1);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       load, launch, park;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  dac_frame_ctrl #(
    .NBITS      (NBITS),
    .GAP_CYCLES (GAP_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .busy   (busy),
    .sync_n (sync_n),
    .sclk   (sclk),
    .load   (load),
    .launch (launch),
    .park   (park)
  );

  dac_frame_piso #(
    .NBITS (NBITS)
  ) u_piso (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (load),
    .launch (launch),
    .park   (park),
    .din    (wr_data),
    .sdata  (sdata)
  );

  // checker state: sclk falls within a frame and the length of the sync high interval
  logic          sclk_d;
  logic [FW-1:0] nfall;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sclk_d <= 1'b1;
      nfall  <= '0;
      hi_cnt <= HI_SAT;
    end else begin
      sclk_d <= sclk;
      if (sync_n)              nfall <= '0;
      else if (sclk_d && !sclk) nfall <= nfall + 1'b1;
      if (!sync_n)             hi_cnt <= '0;
      else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_SYNC_WITH_SCLK_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sync_n) |-> $fell(sclk)); // R2
  AST_DATA_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sync_n && !$rose(sclk)) |-> $stable(sdata)); // R3
  AST_SIXTEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sync_n) |-> (nfall == FALLS_PER_FRAME) && sclk && !sdata); // R4
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> sync_n && sclk && !sdata); // R6
  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sync_n) |-> !$past(busy)); // R7
  AST_SYNC_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sync_n) |-> hi_cnt >= HI_SAT); // R8

endmodule

// File: tb/dac_frame_shifter_test.sv
module dac_frame_shifter_test;

  localparam int NB  = 16;
  localparam int GAP = 2;

  typedef struct packed {
    logic [15:0] word;
    logic [7:0]  ones;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'hA5C3, 8'd8},
    '{16'h0000, 8'd0},
    '{16'hFFFF, 8'd16},
    '{16'h8001, 8'd2},
    '{16'h7FFE, 8'd14},
    '{16'h1234, 8'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        busy, sync_n, sclk, sdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dac_frame_shifter #(.NBITS(NB), .GAP_CYCLES(GAP)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .busy    (busy),
    .sync_n  (sync_n),
    .sclk    (sclk),
    .sdata   (sdata)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(sync_n === 1'b1 && sclk === 1'b1 && sdata === 1'b0 && busy === 1'b0,
          req, {busy, sync_n, sclk, sdata}, 4'b0110);
  endtask

  task automatic run_frame(input logic [15:0] w, input int inj_at, input logic [15:0] inj_w,
                           output logic [15:0] got, output int nf, output int bad_edges,
                           output int flen, output int tail);
    logic prev_sclk, prev_sdata;
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check(sync_n === 1'b0 && sclk === 1'b0, "R2 sync_n and sclk fall together", {sync_n, sclk}, 0);
    check(busy === 1'b1, "R7 busy after accepted write", busy, 1);
    got = '0; nf = 0; bad_edges = 0; flen = 1; tail = 0;
    prev_sclk = sclk; prev_sdata = sdata;
    while (sync_n === 1'b0 && flen < 100) begin
      if (flen == inj_at) begin wr_en = 1'b1; wr_data = inj_w; end
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
      if (sync_n === 1'b0) begin
        flen++;
        if (sdata !== prev_sdata && !(!prev_sclk && sclk)) bad_edges++;
        if (prev_sclk && !sclk) begin
          got = {got[14:0], sdata};
          nf++;
        end
      end
      prev_sclk = sclk; prev_sdata = sdata;
    end
    check(sclk === 1'b1 && sdata === 1'b0, "R4 end-of-frame levels", {sclk, sdata}, 2'b10);
    while (busy === 1'b1 && tail < 20) begin
      tail++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    int nf, bad_edges, flen, tail, ones, hi;

    // R9 reset state
    repeat (3) @(negedge clk);
    check_idle("R9 idle during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R6 idle after reset release");

    // table of words
    for (int i = 0; i < 6; i++) begin
      run_frame(VECS[i].word, -1, '0, got, nf, bad_edges, flen, tail);
      ones = $countones(got);
      check(got === VECS[i].word, "R1 word sent msb first", got, VECS[i].word);
      check(ones == int'(VECS[i].ones), "R1 count of one bits", ones, VECS[i].ones);
      check(nf == NB, "R4 sixteen sampling falls", nf, NB);
      check(bad_edges == 0, "R3 sdata only moves on sclk rise", bad_edges, 0);
      check(flen == 2*NB+1, "R5 frame length in cycles", flen, 2*NB+1);
      check(tail == GAP, "R7 busy tail after sync rise", tail, GAP);
      check_idle("R6 idle between frames");
    end

    // R7 / R10: strobe in the middle of a frame is ignored
    run_frame(16'hC0DE, 10, 16'h5555, got, nf, bad_edges, flen, tail);
    check(got === 16'hC0DE, "R10 mid-frame strobe leaves data intact", got, 16'hC0DE);
    check(flen == 2*NB+1, "R7 mid-frame strobe does not restart frame", flen, 2*NB+1);

    // R7: strobe in the guard interval is ignored
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h3C3C;
    @(negedge clk); wr_en = 1'b0;
    while (sync_n === 1'b0) @(negedge clk);
    wr_en = 1'b1; wr_data = 16'hFFFF;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    hi = 0;
    for (int k = 0; k < 6; k++) begin
      if (sync_n === 1'b1) hi++;
      @(negedge clk);
    end
    check(hi == 6, "R7 guard-interval strobe starts no frame", hi, 6);
    check_idle("R6 idle after ignored strobe");

    // R8: strobe held high, back-to-back frames
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h9696;
    @(negedge clk);
    while (sync_n === 1'b0) @(negedge clk);
    hi = 0;
    while (sync_n === 1'b1 && hi < 50) begin
      hi++;
      @(negedge clk);
    end
    wr_en = 1'b0; wr_data = '0;
    check(hi == GAP+1, "R8 sync_n high between frames", hi, GAP+1);
    while (busy === 1'b1) @(negedge clk);

    // R9: reset in the middle of a frame, then R5 counter restart
    @(negedge clk); wr_en = 1'b1; wr_data = 16'hBEEF;
    @(negedge clk); wr_en = 1'b0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R9 outputs idle at once on reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R9 idle after mid-frame reset");
    run_frame(16'h0F0F, -1, '0, got, nf, bad_edges, flen, tail);
    check(got === 16'h0F0F, "R1 word after reset", got, 16'h0F0F);
    check(nf == NB, "R5 counter restarted after reset", nf, NB);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule